// File: doc/BRIEF.md
# CPU Clock-Enable Power Sequencer

This controller decides when a CPU's oscillator runs and when the CPU core receives its clock. It runs from an always-on slow clock, so it keeps working while the core clock is gated. It has two outputs. `osc_en` switches the oscillator on. `core_clk_en` lets clocks reach the core. After reset the oscillator may start at once, but the core clock stays off until a separate stabilization timer reports a stable oscillator. Releasing the core clock early would leave parts of the chip held in reset.

There are two low-power modes, entered by single-cycle requests from the core. A halt request gates only the core clock, so the rest of the system keeps its clock. A pending interrupt ends the halt. A stop request switches off both the oscillator and the core clock. Only the external wake line ends a stop. It restarts the oscillator and then waits for a fresh stable indication before releasing the core. Leaving stop passes through a wake-wait state of its own rather than the reset-wait state, so execution resumes instead of restarting. The wake line and the stable indication are asynchronous and pass through synchronizers. The stable indication is forced low while the oscillator is off.

Top module: `clk_pwr_seq`

## Requirements
- R1: While reset is asserted, and after its release until the core clock is first granted, `state_o` is 0 (reset wait), `osc_en` is 1 and `core_clk_en` is 0.
- R2: In either wait state, `core_clk_en` first reads 1 on the third rising clock edge after `osc_ready_in` rises (two synchronizer stages plus the state register). It is never 1 before then, and never 1 while the modelled stable indication is low. `state_o` then reads 1 (run).
- R3: A `stop_req` seen in run moves the block to state 3 (stopped) at the next edge, with `osc_en` 0 and `core_clk_en` 0. It stays there until the wake line is seen high.
- R4: In stopped, the third rising edge after `wake_in` rises moves the block to state 4 (wake wait), with `osc_en` 1 and `core_clk_en` 0. It never goes to state 0.
- R5: A `halt_req` seen in run, without `stop_req`, moves the block to state 2 (halted) at the next edge, with `core_clk_en` 0 and `osc_en` 1.
- R6: In halted, `irq_pend` high at an edge returns the block to run at that edge. The wake line has no effect in halted.
- R7: When `halt_req` and `stop_req` are both high in the same run cycle, the block enters stopped.
- R8: Halt and stop requests are ignored in every state except run. `irq_pend` is ignored in every state except halted.
- R9: While `osc_en` is 0, a high `osc_ready_in` is treated as low. It neither changes the state nor leaves a stale level in the synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_aon | input | 1 | Always-on slow clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| halt_req | input | 1 | Single-cycle request to gate the core clock |
| stop_req | input | 1 | Single-cycle request to stop the oscillator and core clock |
| irq_pend | input | 1 | Interrupt pending; ends halted |
| wake_in | input | 1 | Asynchronous wake line; ends stopped |
| osc_ready_in | input | 1 | Asynchronous oscillator-stable indication from the timer |
| osc_en | output | 1 | Oscillator enable |
| core_clk_en | output | 1 | Core clock enable |
| state_o | output | 3 | Current state: 0 reset wait, 1 run, 2 halted, 3 stopped, 4 wake wait |

## Verification
Two collisions matter. The first is a halt request and a stop request arriving in the same run cycle. The bench drives both pulses on the same falling edge and expects stopped one edge later. The second is the wake line held high while halted, together with new halt and stop requests there. The bench holds wake for several cycles, then pulses both requests, and expects the state to stay halted until the interrupt arrives. A timer model with a swept delay produces the stable indication. The bench checks the release of the core clock against that model's edge, counted in whole cycles.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    PS_WAIT_RST  = 3'd0,
    PS_RUN       = 3'd1,
    PS_HALT      = 3'd2,
    PS_STOP      = 3'd3,
    PS_WAIT_WAKE = 3'd4
  } pwr_state_t;
endpackage

// File: rtl/pwr_rst_sync.sv
module pwr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/pwr_bit_sync.sv
module pwr_bit_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] clr,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    logic [STAGES-1:0] sh_d;

    always_comb begin
      if (clr[b]) sh_d = '0;
      else        sh_d = {sh_q[STAGES-2:0], d[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= sh_d;
    end

    assign q[b] = sh_q[STAGES-1];
  end
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import pwr_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               halt_req,
  input  logic               stop_req,
  input  logic               irq_pend,
  input  logic               wake_s,
  input  logic               osc_rise,
  output logic [STATE_W-1:0] state_o,
  output logic               osc_en,
  output logic               core_clk_en
);
  pwr_state_t state_q, state_d;
  logic       waiting;

  assign waiting = (state_q == PS_WAIT_RST) || (state_q == PS_WAIT_WAKE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_WAIT_RST, PS_WAIT_WAKE: if (osc_rise) state_d = PS_RUN;
      PS_RUN: begin
        if (stop_req)      state_d = PS_STOP;
        else if (halt_req) state_d = PS_HALT;
      end
      PS_HALT: if (irq_pend) state_d = PS_RUN;
      PS_STOP: if (wake_s)   state_d = PS_WAIT_WAKE;
      default: state_d = PS_WAIT_RST;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PS_WAIT_RST;
    else        state_q <= state_d;
  end

  assign state_o     = state_q;
  assign osc_en      = (state_q != PS_STOP);
  assign core_clk_en = (state_q == PS_RUN);

  // R3
  stop_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_RUN && stop_req) |=> (state_q == PS_STOP));
  // R3
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_STOP && !wake_s) |=> (state_q == PS_STOP));
  // R5
  halt_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_RUN && halt_req && !stop_req) |=> (state_q == PS_HALT));
  // R6
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_HALT && !irq_pend) |=> (state_q == PS_HALT));
  // R2
  wait_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !osc_rise) |=> (state_q != PS_RUN));
  // R4
  wake_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_STOP) |=> (state_q != PS_WAIT_RST));
endmodule

// File: rtl/clk_pwr_seq.sv
module clk_pwr_seq
  import pwr_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic               clk_aon,
  input  logic               rst_n,
  input  logic               halt_req,
  input  logic               stop_req,
  input  logic               irq_pend,
  input  logic               wake_in,
  input  logic               osc_ready_in,
  output logic               osc_en,
  output logic               core_clk_en,
  output logic [STATE_W-1:0] state_o
);
  localparam int SYN_W = 2;
  localparam int OSC_B = 0;
  localparam int WAK_B = 1;

  logic             srst_n;
  logic [SYN_W-1:0] syn_d, syn_q, syn_clr;
  logic             osc_ok, osc_prev_q, osc_rise;

  pwr_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk_aon), .arst_n(rst_n), .srst_n(srst_n)
  );

  assign syn_d[OSC_B]   = osc_ready_in;
  assign syn_d[WAK_B]   = wake_in;
  assign syn_clr[OSC_B] = ~osc_en;
  assign syn_clr[WAK_B] = 1'b0;

  pwr_bit_sync #(.WIDTH(SYN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_aon), .rst_n(srst_n), .clr(syn_clr), .d(syn_d), .q(syn_q)
  );

  assign osc_ok = syn_q[OSC_B] & osc_en;

  always_ff @(posedge clk_aon or negedge srst_n) begin
    if (!srst_n) osc_prev_q <= 1'b0;
    else         osc_prev_q <= osc_ok;
  end

  assign osc_rise = osc_ok & ~osc_prev_q;

  pwr_fsm u_fsm (
    .clk(clk_aon), .rst_n(srst_n), .halt_req(halt_req), .stop_req(stop_req),
    .irq_pend(irq_pend), .wake_s(syn_q[WAK_B]), .osc_rise(osc_rise),
    .state_o(state_o), .osc_en(osc_en), .core_clk_en(core_clk_en)
  );

  // R2
  clk_grant_chk: assert property (@(posedge clk_aon) disable iff (!srst_n)
    $rose(core_clk_en) |-> ($past(osc_rise) || $past(irq_pend)));
  // R9
  osc_gate_chk: assert property (@(posedge clk_aon) disable iff (!srst_n)
    !osc_en |=> !syn_q[OSC_B]);
  // R1
  clk_needs_osc_chk: assert property (@(posedge clk_aon) disable iff (!srst_n)
    core_clk_en |-> osc_en);
endmodule

// File: tb/clk_pwr_seq_test.sv
module clk_pwr_seq_test;
  logic clk = 1'b0;
  logic rst_n, halt_req, stop_req, irq_pend, wake_in, force_rdy;
  logic osc_en, core_clk_en;
  logic [2:0] state_o;
  logic stable_m;
  int   cnt_m;
  int   dly;
  int   checks = 0;
  int   fails  = 0;
  logic clk_prev;

  always #4 clk = ~clk;

  clk_pwr_seq uut (
    .clk_aon(clk), .rst_n(rst_n), .halt_req(halt_req), .stop_req(stop_req),
    .irq_pend(irq_pend), .wake_in(wake_in), .osc_ready_in(stable_m | force_rdy),
    .osc_en(osc_en), .core_clk_en(core_clk_en), .state_o(state_o)
  );

  // stabilization timer model: delay dly edges after oscillator enable
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin cnt_m <= 0; stable_m <= 1'b0; end
    else if (!osc_en) begin cnt_m <= 0; stable_m <= 1'b0; end
    else if (cnt_m >= dly) stable_m <= 1'b1;
    else cnt_m <= cnt_m + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_st(input string req, input int exp);
    chk(state_o == exp, req, state_o, exp);
  endtask

  // R2 monitor: core clock never granted while modelled stable is low
  always @(negedge clk) begin
    if (rst_n === 1'b1 && core_clk_en === 1'b1 && clk_prev === 1'b0)
      chk(stable_m == 1'b1, "R2 grant-while-unstable", stable_m, 1);
    clk_prev <= core_clk_en;
  end

  task automatic wait_run(input string req);
    int guard = 0;
    while (!stable_m && guard < 60) begin
      chk(core_clk_en == 1'b0, req, core_clk_en, 0);
      step(); guard++;
    end
    step(); chk(core_clk_en == 1'b0, "R2 edge+1", core_clk_en, 0);
    step(); chk(core_clk_en == 1'b0, "R2 edge+2", core_clk_en, 0);
    step(); chk(core_clk_en == 1'b1, "R2 edge+3", core_clk_en, 1);
    chk_st("R2 run", 1);
  endtask

  task automatic pulse(input bit h, input bit s);
    halt_req = h; stop_req = s; step(); halt_req = 0; stop_req = 0;
  endtask

  task automatic wake_up();
    wake_in = 1; step(2); chk_st("R4 wake sync", 3);
    step(); chk_st("R4 wake wait", 4);
    chk(osc_en == 1'b1, "R4 osc", osc_en, 1);
    chk(core_clk_en == 1'b0, "R4 clk", core_clk_en, 0);
    wake_in = 0;
    pulse(1, 1); chk_st("R8 wait ignores requests", 4);
    wait_run("R2 wake wait");
  endtask

  initial begin
    rst_n = 0; halt_req = 0; stop_req = 0; irq_pend = 0; wake_in = 0; force_rdy = 0;
    clk_prev = 0; dly = 2;
    for (int d = 2; d <= 7; d++) begin
      dly = d;
      rst_n = 0; step(3);
      chk_st("R1 reset state", 0);
      chk(osc_en == 1'b1, "R1 osc", osc_en, 1);
      chk(core_clk_en == 1'b0, "R1 clk", core_clk_en, 0);
      rst_n = 1;
      wait_run("R1 held until stable");
      irq_pend = 1; step(); chk_st("R8 irq in run", 1); irq_pend = 0;
      pulse(1, 0); chk_st("R5 halt", 2);
      chk(osc_en == 1'b1, "R5 osc", osc_en, 1);
      chk(core_clk_en == 1'b0, "R5 clk", core_clk_en, 0);
      wake_in = 1; step(5); chk_st("R6 wake ignored in halt", 2); wake_in = 0;
      pulse(1, 1); chk_st("R8 halt ignores requests", 2);
      irq_pend = 1; step(); chk_st("R6 irq exit", 1); irq_pend = 0;
      chk(core_clk_en == 1'b1, "R6 clk", core_clk_en, 1);
      pulse(0, 1); chk_st("R3 stop", 3);
      chk(osc_en == 1'b0, "R3 osc", osc_en, 0);
      chk(core_clk_en == 1'b0, "R3 clk", core_clk_en, 0);
      irq_pend = 1; step(3); chk_st("R8 irq in stop", 3); irq_pend = 0;
      pulse(1, 0); chk_st("R8 halt in stop", 3);
      force_rdy = 1; step(5); chk_st("R9 ready while off", 3);
      chk(core_clk_en == 1'b0, "R9 clk", core_clk_en, 0);
      force_rdy = 0; step(2);
      wake_up();
      pulse(1, 1); chk_st("R7 stop wins", 3);
      chk(osc_en == 1'b0, "R7 osc", osc_en, 0);
      wake_up();
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule